// File: doc/BRIEF.md
# I2C SCL Clock Divider

This block produces the serial-clock timing for an I2C master. A clock-control word supplies a prescaler and a stretch count. The prescaler divides the module clock into an internal clock. The stretch count lengthens a fixed base period in steps of eight internal cycles. A separate compensation count is added on top. It covers the SCL fall time, the rise time and an internal delay, converted to internal cycles and rounded up. Software works it out per channel: 35 ns plus 200 ns plus 50 ns on channel 0, and plus 5 ns on the other channels. The internal clock is meant to stay below 20 MHz.

Each SCL period is split into a low phase and a high phase. Any odd cycle goes to the low phase. The byte controller receives three single-cycle strobes: one where the low phase begins, one at the middle of the low phase where SDA may change, and one where SCL rises.

The counters hold at zero while the master is disabled, so the first low phase after enabling always has its full length. A new clock-control word or compensation count written during a transfer is taken up only at the next period boundary. The block has no data stream: all pins are plain control and status levels, so no valid/ready handshake or back-pressure applies.

Top module: `scl_clkgen`

## Requirements
- R1: While `master_en` is 0 (and after reset), `scl_o` is 1 and all three strobes are 0. Dropping `master_en` during a period releases `scl_o` in that same cycle.
- R2: `clk_ctrl[2:0]` is the prescaler `p`. One internal cycle lasts `p+1` module clocks.
- R3: `clk_ctrl[8:3]` is the stretch count `s` and `comp_cycles` is `F`. The period is `P = 20 + 8*s + F` internal cycles, so consecutive `low_tick` strobes are `P*(p+1)` module clocks apart.
- R4: `scl_o` is 0 for `L = ceil(P/2)` internal cycles from `low_tick`, then 1 for `floor(P/2)` internal cycles.
- R5: `sda_tick` pulses `floor(L/2)*(p+1)` module clocks after each `low_tick`.
- R6: Each strobe lasts one module clock, and at most one strobe is high in any cycle. `rise_tick` coincides with `scl_o` going from 0 to 1. `low_tick` coincides with `scl_o` being 0.
- R7: `low_tick` is high in the first cycle in which `master_en` is 1. The first period after enabling has the full length set by the configuration.
- R8: A change of `clk_ctrl` or `comp_cycles` while enabled does not alter the period in progress. It takes effect from the next `low_tick`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| master_en | input | 1 | Master enabled; 0 holds and restarts the divider |
| clk_ctrl | input | 9 | [2:0] prescaler, [8:3] stretch count |
| comp_cycles | input | 6 | Compensation count F in internal cycles |
| scl_o | output | 1 | SCL level to drive (1 = released high) |
| low_tick | output | 1 | Strobe at start of low phase |
| sda_tick | output | 1 | Strobe at the SDA update point |
| rise_tick | output | 1 | Strobe at SCL rising edge |

## Verification
A wrong prescaler count or a wrong phase-counter count shifts a strobe or an `scl_o` edge by at least one module clock within the first period after enabling. Comparing the ports on every cycle therefore exposes it within a few hundred cycles. A configuration register that reloads at the wrong moment does not show until the first boundary after a mid-period write. At that boundary the period in progress becomes shorter or longer than expected, so that case is driven on purpose with different prescaler and stretch values. Counters that fail to clear on disable show up as a missing or late `low_tick` in the first cycle after re-enabling.

// File: rtl/scl_clkgen_pkg.sv
package scl_clkgen_pkg;
  localparam int BASE_CYC     = 20;
  localparam int STRETCH_STEP = 8;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOW  = 2'd1,
    PH_HIGH = 2'd2
  } scl_phase_e;
endpackage

// File: rtl/scl_prescaler.sv
module scl_prescaler #(
  parameter int PSC_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [PSC_W-1:0] div_sel,
  output logic             step,
  output logic             at_first
);
  logic [PSC_W-1:0] pre_cnt;

  assign step     = (pre_cnt == div_sel);
  assign at_first = (pre_cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               pre_cnt <= '0;
    else if (!run || step)    pre_cnt <= '0;
    else                      pre_cnt <= pre_cnt + 1'b1;
  end
endmodule

// File: rtl/scl_cfg_hold.sv
module scl_cfg_hold
  import scl_clkgen_pkg::*;
#(
  parameter int PSC_W  = 3,
  parameter int STR_W  = 6,
  parameter int COMP_W = 6,
  parameter int PER_W  = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              wrap,
  input  logic [PSC_W-1:0]  cfg_psc,
  input  logic [STR_W-1:0]  cfg_str,
  input  logic [COMP_W-1:0] cfg_comp,
  output logic [PSC_W-1:0]  psc_q,
  output logic [PER_W-1:0]  per_len,
  output logic [PER_W-1:0]  low_len,
  output logic [PER_W-1:0]  sda_pt
);
  logic [STR_W-1:0]  str_q;
  logic [COMP_W-1:0] comp_q;

  // Settings are sampled only while idle or at the last cycle of a period.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      psc_q  <= '0;
      str_q  <= '0;
      comp_q <= '0;
    end else if (!run || wrap) begin
      psc_q  <= cfg_psc;
      str_q  <= cfg_str;
      comp_q <= cfg_comp;
    end
  end

  always_comb begin
    per_len = PER_W'(BASE_CYC) + PER_W'(str_q) * PER_W'(STRETCH_STEP)
            + PER_W'(comp_q);
    low_len = (per_len + PER_W'(1)) >> 1;
    sda_pt  = low_len >> 1;
  end
endmodule

// File: rtl/scl_phase_ctr.sv
module scl_phase_ctr
  import scl_clkgen_pkg::*;
#(
  parameter int PER_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             step,
  input  logic             at_first,
  input  logic [PER_W-1:0] per_len,
  input  logic [PER_W-1:0] low_len,
  input  logic [PER_W-1:0] sda_pt,
  output logic             wrap,
  output scl_phase_e       phase,
  output logic             low_tick,
  output logic             sda_tick,
  output logic             rise_tick
);
  logic [PER_W-1:0] ph_cnt;
  logic             last;

  assign last = (ph_cnt == per_len - PER_W'(1));
  assign wrap = run & step & last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        ph_cnt <= '0;
    else if (!run)     ph_cnt <= '0;
    else if (step)     ph_cnt <= last ? '0 : ph_cnt + 1'b1;
  end

  always_comb begin
    if (!run)                 phase = PH_IDLE;
    else if (ph_cnt < low_len) phase = PH_LOW;
    else                      phase = PH_HIGH;
  end

  assign low_tick  = run & at_first & (ph_cnt == '0);
  assign sda_tick  = run & at_first & (ph_cnt == sda_pt);
  assign rise_tick = run & at_first & (ph_cnt == low_len);
endmodule

// File: rtl/scl_clkgen.sv
module scl_clkgen
  import scl_clkgen_pkg::*;
#(
  parameter int PSC_W  = 3,
  parameter int STR_W  = 6,
  parameter int COMP_W = 6
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    master_en,
  input  logic [PSC_W+STR_W-1:0]  clk_ctrl,
  input  logic [COMP_W-1:0]       comp_cycles,
  output logic                    scl_o,
  output logic                    low_tick,
  output logic                    sda_tick,
  output logic                    rise_tick
);
  localparam int PER_MAX = BASE_CYC + STRETCH_STEP * ((1 << STR_W) - 1)
                         + (1 << COMP_W) - 1;
  localparam int PER_W   = $clog2(PER_MAX + 1);

  logic [PSC_W-1:0] psc_q;
  logic [PER_W-1:0] per_len, low_len, sda_pt;
  logic             step, at_first, wrap;
  scl_phase_e       phase;

  scl_prescaler #(.PSC_W(PSC_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .run(master_en), .div_sel(psc_q),
    .step(step), .at_first(at_first)
  );

  scl_cfg_hold #(.PSC_W(PSC_W), .STR_W(STR_W), .COMP_W(COMP_W), .PER_W(PER_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .run(master_en), .wrap(wrap),
    .cfg_psc(clk_ctrl[PSC_W-1:0]), .cfg_str(clk_ctrl[PSC_W+STR_W-1:PSC_W]),
    .cfg_comp(comp_cycles), .psc_q(psc_q), .per_len(per_len),
    .low_len(low_len), .sda_pt(sda_pt)
  );

  scl_phase_ctr #(.PER_W(PER_W)) u_ph (
    .clk(clk), .rst_n(rst_n), .run(master_en), .step(step), .at_first(at_first),
    .per_len(per_len), .low_len(low_len), .sda_pt(sda_pt), .wrap(wrap),
    .phase(phase), .low_tick(low_tick), .sda_tick(sda_tick), .rise_tick(rise_tick)
  );

  assign scl_o = (phase != PH_LOW);
endmodule

// File: rtl/scl_clkgen_chk.sv
module scl_clkgen_chk (
  input logic clk,
  input logic rst_n,
  input logic master_en,
  input logic scl_o,
  input logic low_tick,
  input logic sda_tick,
  input logic rise_tick
);
  assert_idle_released_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !master_en |-> (scl_o && !low_tick && !sda_tick && !rise_tick));

  assert_one_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({low_tick, sda_tick, rise_tick}));

  assert_rise_edge_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rise_tick |-> $rose(scl_o));

  assert_low_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
    low_tick |-> !scl_o);

  assert_sda_in_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    sda_tick |-> !scl_o);

  assert_enable_starts_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(master_en) |-> low_tick);
endmodule

bind scl_clkgen scl_clkgen_chk u_chk (
  .clk(clk), .rst_n(rst_n), .master_en(master_en), .scl_o(scl_o),
  .low_tick(low_tick), .sda_tick(sda_tick), .rise_tick(rise_tick)
);

// File: tb/scl_clkgen_bench.sv
`timescale 1ns/1ps
module scl_clkgen_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       master_en = 1'b0;
  logic [8:0] clk_ctrl = '0;
  logic [5:0] comp_cycles = '0;
  logic       scl_o, low_tick, sda_tick, rise_tick;

  int vectors = 0;
  int errors  = 0;
  bit done    = 1'b0;

  always #10 clk = ~clk;

  scl_clkgen u_scl_clkgen (
    .clk(clk), .rst_n(rst_n), .master_en(master_en), .clk_ctrl(clk_ctrl),
    .comp_cycles(comp_cycles), .scl_o(scl_o), .low_tick(low_tick),
    .sda_tick(sda_tick), .rise_tick(rise_tick)
  );

  function automatic int per_of(int s, int f);
    return 20 + 8 * s + f;
  endfunction

  // Expected {scl, low, sda, rise} at module clock k after enabling.
  function automatic logic [3:0] expect_at(int p, int s, int f, int k);
    int d   = p + 1;
    int P   = per_of(s, f);
    int L   = (P + 1) / 2;
    int sub = k % d;
    int pos = (k / d) % P;
    return {pos >= L, sub == 0 && pos == 0, sub == 0 && pos == L / 2,
            sub == 0 && pos == L};
  endfunction

  task automatic check_vec(string tag, logic [3:0] exp);
    logic [3:0] got = {scl_o, low_tick, sda_tick, rise_tick};
    vectors++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s {scl,low,sda,rise} got %b expected %b at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic set_cfg(int p, int s, int f);
    clk_ctrl    = {6'(s), 3'(p)};
    comp_cycles = 6'(f);
  endtask

  task automatic run_case(int p, int s, int f, int nper, string tag);
    int n = nper * per_of(s, f) * (p + 1);
    @(negedge clk);
    set_cfg(p, s, f);
    master_en = 1'b0;
    @(negedge clk);
    master_en = 1'b1;
    #1;
    for (int k = 0; k < n; k++) begin
      if (k > 0) @(negedge clk);
      check_vec(tag, expect_at(p, s, f, k));
    end
    @(negedge clk);
    master_en = 1'b0;
    #1;
    check_vec("R1 after disable", 4'b1000);
  endtask

  initial begin
    void'($urandom(32'd2024));
    #1;
    check_vec("R1 in reset", 4'b1000);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_vec("R1 idle after reset", 4'b1000);

    run_case(0, 0, 0, 3, "R3 minimum period");
    run_case(1, 0, 1, 3, "R4 odd period");
    run_case(2, 5, 3, 2, "R5 sda point");
    run_case(7, 63, 63, 2, "R2 maximum division");
    for (int p = 0; p < 8; p++) run_case(p, 1, 2, 2, "R2 prescaler sweep");

    for (int i = 0; i < 10; i++)
      run_case(int'($urandom_range(7, 0)), int'($urandom_range(31, 0)),
               int'($urandom_range(63, 0)), 2, "R3 random");

    // R7: disable in the middle of a period, then re-enable.
    @(negedge clk);
    set_cfg(1, 2, 4);
    @(negedge clk);
    master_en = 1'b1;
    repeat (30) @(negedge clk);
    master_en = 1'b0;
    #1;
    check_vec("R1 released on disable", 4'b1000);
    run_case(1, 2, 4, 2, "R7 restart full period");

    // R8: change settings at cycle 5 of the first period.
    begin
      int k0 = per_of(3, 7) * 2;
      int n  = k0 + 2 * per_of(10, 1) * 4;
      @(negedge clk);
      set_cfg(1, 3, 7);
      @(negedge clk);
      master_en = 1'b1;
      #1;
      for (int k = 0; k < n; k++) begin
        if (k > 0) @(negedge clk);
        if (k < k0) check_vec("R8 old period kept", expect_at(1, 3, 7, k));
        else        check_vec("R8 new period", expect_at(3, 10, 1, k - k0));
        if (k == 5) set_cfg(3, 10, 1);
      end
      @(negedge clk);
      master_en = 1'b0;
    end

    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog expired, got running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule